// File: doc/BRIEF.md
# DRAM Access State Sequencer

This block runs one read or one write to an asynchronous DRAM for a bus master. It accepts a request only when idle. It then walks a fixed state chain: a precharge state, a row state in which RAS falls, zero to three programmable row-hold states, a first column state and a second column state. At the end it releases the strobes and raises a single-cycle completion pulse. During the access it multiplexes the row and column address onto one address bus. It drives RAS on the line of the selected memory area, separate CAS strobes for the upper and lower byte lane, and WE for writes or OE for reads.

The row-hold count comes from a 2-bit configuration input. It stretches the time between RAS falling and the column address appearing, which sets the row-address hold time and the read access time for slower devices or faster clocks. The count is sampled once, when a request is accepted, so the shape of an access in progress never changes. The RAS output is a vector with one active-low line per memory area. Index 0 to 3 stands for the four areas whose chip-select pin can double as RAS.

Top module: `dram_access_seq`

## Requirements
- R1: After a request is accepted on a rising edge, the access occupies, in order, one precharge cycle, one row cycle, N row-hold cycles, one first-column cycle and one second-column cycle. `done` is high in the cycle that follows, so `done` comes 5+N cycles after the accepting edge.
- R2: RAS (`ras_n[req_area]`, active low) is low from the row cycle through the second-column cycle inclusive. Every other `ras_n` line stays high, and all lines are high in the precharge cycle and while idle.
- R3: N equals the value of `cfg_hold` (0 to 3) sampled on the accepting edge.
- R4: `dram_addr` carries the row address in the precharge, row and every row-hold cycle. It carries the column address in both column cycles, and it is zero while idle.
- R5: `ucas_n` and `lcas_n` go low only in the second-column cycle: `ucas_n` when `req_be[1]` was set and `lcas_n` when `req_be[0]` was set at acceptance.
- R6: On a read (`req_write`=0), `oe_n` is low in both column cycles and `we_n` stays high. `dq_in` is captured at the end of the second-column cycle and appears on `rdata` together with `done`.
- R7: On a write (`req_write`=1), `we_n` is low and `dq_oe` is high in both column cycles, with `dq_out` equal to the accepted write data. `oe_n` stays high.
- R8: `req_ready` is high only while idle, including the `done` cycle. `done` lasts exactly one cycle. Request inputs that change while the block is busy have no effect on the access in progress.
- R9: A change of `cfg_hold` after acceptance does not alter the row-hold count of the running access.
- R10: Every access starts with a precharge cycle with all RAS lines high, including one accepted in the `done` cycle of the previous access.
- R11: While reset is asserted, all strobes are high, `dq_oe` and `done` are low, `dram_addr` is zero and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hold | input | 2 | Number of row-hold states for the next access |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_area | input | 2 | Memory area index selecting the RAS line |
| req_row | input | ADDR_W | Row address |
| req_col | input | ADDR_W | Column address |
| req_be | input | 2 | Byte enables, bit 1 upper lane, bit 0 lower lane |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |
| dram_addr | output | ADDR_W | Multiplexed DRAM address |
| ras_n | output | N_AREAS | Active-low RAS, one line per area |
| ucas_n | output | 1 | Active-low CAS, upper byte lane |
| lcas_n | output | 1 | Active-low CAS, lower byte lane |
| we_n | output | 1 | Active-low write enable |
| oe_n | output | 1 | Active-low output enable |
| dq_out | output | DATA_W | Write data toward the DRAM |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | DATA_W | Read data from the DRAM |

## Verification
The accepting edge is cycle 0. Every strobe and the address follow the registered state, so their values for cycle c hold during the c-th clock period after that edge: RAS in cycles 2 to 4+N, the column address from 3+N, CAS at 4+N, and `done` with `rdata` at 5+N. The bench drives on falling edges and samples every output at each falling edge from cycle 1 to 5+N. It compares each one with the value expected from the cycle number and the N it expects. Changes to the request and to `cfg_hold` are applied in cycle 1, so their lack of effect shows in the same sampled windows.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PRE  = 3'd1,
      ST_ROW  = 3'd2,
      ST_HOLD = 3'd3,
      ST_COL1 = 3'd4,
      ST_COL2 = 3'd5
   } seq_state_e;

   function automatic logic ras_phase(input seq_state_e st);
      return (st == ST_ROW) || (st == ST_HOLD) || (st == ST_COL1) || (st == ST_COL2);
   endfunction

   function automatic logic col_phase(input seq_state_e st);
      return (st == ST_COL1) || (st == ST_COL2);
   endfunction

endpackage

// File: rtl/dseq_fsm.sv
module dseq_fsm
   import dram_seq_pkg::*;
#(
   parameter int HOLD_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [HOLD_W-1:0] cfg_hold,
   output seq_state_e        state,
   output logic              done
);

   if (HOLD_W < 1 || HOLD_W > 4) begin : g_bad_hold_w
      $error("dseq_fsm: HOLD_W out of range");
   end

   seq_state_e        state_q;
   logic [HOLD_W-1:0] hold_q;
   logic [HOLD_W-1:0] cnt_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         hold_q  <= '0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= (state_q == ST_COL2);
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  hold_q  <= cfg_hold;
                  state_q <= ST_PRE;
               end
            end
            ST_PRE:  state_q <= ST_ROW;
            ST_ROW: begin
               cnt_q   <= hold_q;
               state_q <= (hold_q == '0) ? ST_COL1 : ST_HOLD;
            end
            ST_HOLD: begin
               if (cnt_q <= HOLD_W'(1)) state_q <= ST_COL1;
               else                     cnt_q   <= cnt_q - HOLD_W'(1);
            end
            ST_COL1: state_q <= ST_COL2;
            ST_COL2: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state = state_q;
   assign done  = done_q;

   AST_PRE_TO_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_PRE |=> state_q == ST_ROW); // R1
   AST_NO_HOLD_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ROW && hold_q == '0) |=> state_q == ST_COL1); // R3
   AST_COL2_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_COL2 |=> (done_q && state_q == ST_IDLE)); // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R8
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && state_q != ST_PRE) |-> $stable(hold_q)); // R9
   AST_START_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && start) |=> state_q == ST_PRE); // R10

endmodule

// File: rtl/dseq_addr_mux.sv
module dseq_addr_mux
   import dram_seq_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  seq_state_e        state,
   input  logic [ADDR_W-1:0] row,
   input  logic [ADDR_W-1:0] col,
   output logic [ADDR_W-1:0] addr
);

   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("dseq_addr_mux: ADDR_W must be positive");
   end

   always_comb begin
      unique case (state)
         ST_PRE, ST_ROW, ST_HOLD: addr = row;
         ST_COL1, ST_COL2:        addr = col;
         default:                 addr = '0;
      endcase
   end

endmodule

// File: rtl/dseq_strobes.sv
module dseq_strobes
   import dram_seq_pkg::*;
#(
   parameter int N_AREAS = 4,
   parameter int LANES   = 2,
   localparam int AREA_W = (N_AREAS > 1) ? $clog2(N_AREAS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_state_e        state,
   input  logic [AREA_W-1:0] area,
   input  logic              write,
   input  logic [LANES-1:0]  be,
   output logic [N_AREAS-1:0] ras_n,
   output logic [LANES-1:0]  cas_n,
   output logic              we_n,
   output logic              oe_n,
   output logic              dq_oe
);

   if (N_AREAS < 1) begin : g_bad_areas
      $error("dseq_strobes: N_AREAS must be positive");
   end

   logic ras_on;
   logic col_on;

   assign ras_on = ras_phase(state);
   assign col_on = col_phase(state);

   for (genvar a = 0; a < N_AREAS; a++) begin : g_ras
      assign ras_n[a] = !(ras_on && (area == AREA_W'(a)));
   end

   for (genvar l = 0; l < LANES; l++) begin : g_cas
      assign cas_n[l] = !((state == ST_COL2) && be[l]);
   end

   assign we_n  = !(col_on && write);
   assign oe_n  = !(col_on && !write);
   assign dq_oe = col_on && write;

   AST_RAS_ONE_AREA: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~ras_n) <= 1); // R2
   AST_CAS_IN_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_n != '1) |-> (ras_n != '1)); // R5
   AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !oe_n)); // R6
   AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> !we_n); // R7

endmodule

// File: rtl/dseq_rd_capture.sv
module dseq_rd_capture
   import dram_seq_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_state_e        state,
   input  logic              write,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] rdata
);

   logic              cap_en;
   logic [DATA_W-1:0] rdata_q;

   assign cap_en = (state == ST_COL2) && !write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (cap_en) rdata_q <= dq_in;
   end

   assign rdata = rdata_q;

   AST_RDATA_ONLY_COL2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rdata_q) |-> $past(state) == ST_COL2); // R6

endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
   import dram_seq_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 16,
   parameter int N_AREAS = 4,
   parameter int HOLD_W  = 2,
   localparam int LANES  = DATA_W / 8,
   localparam int AREA_W = (N_AREAS > 1) ? $clog2(N_AREAS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HOLD_W-1:0]  cfg_hold,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_write,
   input  logic [AREA_W-1:0]  req_area,
   input  logic [ADDR_W-1:0]  req_row,
   input  logic [ADDR_W-1:0]  req_col,
   input  logic [LANES-1:0]   req_be,
   input  logic [DATA_W-1:0]  req_wdata,
   output logic               done,
   output logic [DATA_W-1:0]  rdata,
   output logic [ADDR_W-1:0]  dram_addr,
   output logic [N_AREAS-1:0] ras_n,
   output logic               ucas_n,
   output logic               lcas_n,
   output logic               we_n,
   output logic               oe_n,
   output logic [DATA_W-1:0]  dq_out,
   output logic               dq_oe,
   input  logic [DATA_W-1:0]  dq_in
);

   if (LANES != 2 || DATA_W != 8 * LANES) begin : g_bad_data_w
      $error("dram_access_seq: two byte lanes (DATA_W = 16) required");
   end

   seq_state_e        state;
   logic              accept;
   logic              write_q;
   logic [AREA_W-1:0] area_q;
   logic [ADDR_W-1:0] row_q;
   logic [ADDR_W-1:0] col_q;
   logic [LANES-1:0]  be_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  cas_n;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         write_q <= 1'b0;
         area_q  <= '0;
         row_q   <= '0;
         col_q   <= '0;
         be_q    <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         write_q <= req_write;
         area_q  <= req_area;
         row_q   <= req_row;
         col_q   <= req_col;
         be_q    <= req_be;
         wdata_q <= req_wdata;
      end
   end

   dseq_fsm #(.HOLD_W(HOLD_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .cfg_hold (cfg_hold),
      .state    (state),
      .done     (done)
   );

   dseq_addr_mux #(.ADDR_W(ADDR_W)) u_addr (
      .state (state),
      .row   (row_q),
      .col   (col_q),
      .addr  (dram_addr)
   );

   dseq_strobes #(.N_AREAS(N_AREAS), .LANES(LANES)) u_strobes (
      .clk   (clk),
      .rst_n (rst_n),
      .state (state),
      .area  (area_q),
      .write (write_q),
      .be    (be_q),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .oe_n  (oe_n),
      .dq_oe (dq_oe)
   );

   dseq_rd_capture #(.DATA_W(DATA_W)) u_rdcap (
      .clk   (clk),
      .rst_n (rst_n),
      .state (state),
      .write (write_q),
      .dq_in (dq_in),
      .rdata (rdata)
   );

   assign ucas_n = cas_n[1];
   assign lcas_n = cas_n[0];
   assign dq_out = wdata_q;

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready); // R8
   AST_PRE_RAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (ras_n == '1)); // R10
   AST_REQ_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> ($stable(row_q) && $stable(area_q) && $stable(write_q))); // R8

endmodule

// File: tb/dram_access_seq_tb.sv
module dram_access_seq_tb;

   localparam int ADDR_W = 12;
   localparam int DATA_W = 16;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [1:0]        cfg_hold;
   logic              req_valid;
   logic              req_ready;
   logic              req_write;
   logic [1:0]        req_area;
   logic [ADDR_W-1:0] req_row;
   logic [ADDR_W-1:0] req_col;
   logic [1:0]        req_be;
   logic [DATA_W-1:0] req_wdata;
   logic              done;
   logic [DATA_W-1:0] rdata;
   logic [ADDR_W-1:0] dram_addr;
   logic [3:0]        ras_n;
   logic              ucas_n, lcas_n, we_n, oe_n, dq_oe;
   logic [DATA_W-1:0] dq_out;
   logic [DATA_W-1:0] dq_in;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   // responder: read word is the column address mixed with a constant
   assign dq_in = oe_n ? 16'h0000 : (16'(dram_addr) ^ 16'hA5C3);

   dram_access_seq u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .req_valid(req_valid),
      .req_ready(req_ready), .req_write(req_write), .req_area(req_area),
      .req_row(req_row), .req_col(req_col), .req_be(req_be),
      .req_wdata(req_wdata), .done(done), .rdata(rdata), .dram_addr(dram_addr),
      .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n), .we_n(we_n),
      .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
   );

   typedef struct packed {
      logic        wr;
      logic [1:0]  area;
      logic [11:0] row;
      logic [11:0] col;
      logic [1:0]  be;
      logic [15:0] wd;
      logic [1:0]  cfg;
      logic        b2b;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 2'd0, 12'h123, 12'h045, 2'b11, 16'h0000, 2'd0, 1'b0},
      '{1'b1, 2'd1, 12'hABC, 12'h3F0, 2'b01, 16'hBEEF, 2'd1, 1'b0},
      '{1'b0, 2'd2, 12'h7FF, 12'hFFF, 2'b10, 16'h0000, 2'd2, 1'b0},
      '{1'b1, 2'd3, 12'h001, 12'h800, 2'b11, 16'h1234, 2'd3, 1'b1},
      '{1'b0, 2'd3, 12'h555, 12'hAAA, 2'b00, 16'h0000, 2'd3, 1'b0},
      '{1'b1, 2'd0, 12'hF0F, 12'h0F0, 2'b10, 16'h8001, 2'd2, 1'b1},
      '{1'b0, 2'd1, 12'h246, 12'h135, 2'b01, 16'h0000, 2'd1, 1'b1},
      '{1'b1, 2'd2, 12'hFFF, 12'h000, 2'b11, 16'hFFFF, 2'd0, 1'b0}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Called right after a falling edge (or while idle). Drives the request,
   // lets the next rising edge accept it, then checks each cycle 1..5+N.
   // scramble: keep req_valid high and alter the request fields in cycle 1.
   task automatic run_access(input vec_t v, input logic [1:0] cfg_after,
                             input bit scramble);
      int n;
      n = int'(v.cfg);
      req_valid = 1'b1;
      req_write = v.wr;
      req_area  = v.area;
      req_row   = v.row;
      req_col   = v.col;
      req_be    = v.be;
      req_wdata = v.wd;
      cfg_hold  = v.cfg;
      chk("R8", "ready before accept", 32'(req_ready), 32'd1);
      @(posedge clk);
      for (int c = 1; c <= 5 + n; c++) begin
         logic [3:0] exp_ras;
         bit ras_cyc, col_cyc;
         @(negedge clk);
         if (c == 1) begin
            cfg_hold = cfg_after;
            if (scramble) begin
               req_write = ~v.wr;
               req_area  = v.area + 2'd1;
               req_row   = ~v.row;
               req_col   = ~v.col;
               req_be    = ~v.be;
               req_wdata = ~v.wd;
            end else begin
               req_valid = 1'b0;
            end
            chk("R10", "precharge ras_n", 32'(ras_n), 32'hF);
         end
         ras_cyc = (c >= 2) && (c <= 4 + n);
         col_cyc = (c == 3 + n) || (c == 4 + n);
         exp_ras = ras_cyc ? ~(4'b0001 << v.area) : 4'hF;
         chk("R2", "ras_n", 32'(ras_n), 32'(exp_ras));
         if (c <= 2 + n) chk("R4", "row addr", 32'(dram_addr), 32'(v.row));
         if (col_cyc)    chk("R4", "col addr", 32'(dram_addr), 32'(v.col));
         chk("R5", "ucas_n", 32'(ucas_n), 32'(!((c == 4 + n) && v.be[1])));
         chk("R5", "lcas_n", 32'(lcas_n), 32'(!((c == 4 + n) && v.be[0])));
         if (v.wr) begin
            chk("R7", "we_n", 32'(we_n), 32'(!col_cyc));
            chk("R7", "oe_n", 32'(oe_n), 32'd1);
            chk("R7", "dq_oe", 32'(dq_oe), 32'(col_cyc));
            if (col_cyc) chk("R7", "dq_out", 32'(dq_out), 32'(v.wd));
         end else begin
            chk("R6", "oe_n", 32'(oe_n), 32'(!col_cyc));
            chk("R6", "we_n", 32'(we_n), 32'd1);
            chk("R6", "dq_oe", 32'(dq_oe), 32'd0);
         end
         chk("R1", "done", 32'(done), 32'(c == 5 + n));
         chk("R8", "ready", 32'(req_ready), 32'(c == 5 + n));
         if (c == 5 + n && !v.wr)
            chk("R6", "rdata", 32'(rdata), 32'(16'(v.col) ^ 16'hA5C3));
      end
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      vec_t v;
      rst_n = 1'b0;
      req_valid = 1'b0; req_write = 1'b0; req_area = '0; req_row = '0;
      req_col = '0; req_be = '0; req_wdata = '0; cfg_hold = '0;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11", "ras_n", 32'(ras_n), 32'hF);
      chk("R11", "cas", 32'({ucas_n, lcas_n, we_n, oe_n}), 32'hF);
      chk("R11", "dq_oe/done", 32'({dq_oe, done}), 32'd0);
      chk("R11", "addr", 32'(dram_addr), 32'd0);
      chk("R11", "ready", 32'(req_ready), 32'd1);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk; b2b entries keep valid high and scramble the inputs
      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         run_access(v, v.cfg, v.b2b);
         if (!v.b2b) begin
            req_valid = 1'b0;
            @(negedge clk);
            chk("R8", "idle done low", 32'(done), 32'd0);
         end
      end
      req_valid = 1'b0;
      repeat (2) @(negedge clk);

      // R9: configuration raised from 0 to 3 mid-access keeps N = 0
      v = '{1'b0, 2'd1, 12'h321, 12'h654, 2'b11, 16'h0, 2'd0, 1'b0};
      run_access(v, 2'd3, 1'b0);
      // R9/R3: configuration dropped from 3 to 0 mid-access keeps N = 3
      v = '{1'b1, 2'd2, 12'h0AA, 12'h0BB, 2'b01, 16'h5A5A, 2'd3, 1'b0};
      run_access(v, 2'd0, 1'b0);
      repeat (2) @(negedge clk);

      // R8: request held off during reset-idle gap then single idle cycle
      chk("R8", "idle ras_n", 32'(ras_n), 32'hF);
      chk("R4", "idle addr", 32'(dram_addr), 32'd0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule